// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block is the address side of an integer unit that walks up to eight ring buffers at once. Each ring has its own context: a start address, a length in words and a current pointer. A request names one ring and a signed step. The block returns the ring's current pointer as the address. In the same cycle it post-modifies the pointer by the step and folds the result back into the window `[start, start + length)`. No software correction is needed, and the window may sit at any address with any length.

Contexts are loaded through a write port that selects one field of one ring. Each write takes one cycle to retire into the context. A request that names the ring being written during that cycle would read a stale value, so the block raises a stall and holds off the request until the write has landed. A length of zero turns wrapping off for that ring and gives plain linear post-modify addressing.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset `addr_valid`, `addr_out` and `stall` are 0. Every ring has start 0, length 0 and pointer 0.
- R2: A request accepted in cycle N drives `addr_valid` high and `addr_out` equal to the ring's pre-update pointer in cycle N+1. Requests to the same ring in consecutive cycles each see the previous update, with no stall.
- R3: With a nonzero length, a forward step that carries the offset (pointer − start) to the length or beyond subtracts the length.
- R4: With a nonzero length, a backward step that makes the offset negative adds the length.
- R5: The start address and the length may take any values, with no alignment and no power-of-two restriction.
- R6: A ring whose length is 0 updates its pointer as pointer + step, modulo 2^AW, with no wrap.
- R7: The eight rings are independent. A request or a write to one ring leaves the others unchanged.
- R8: A write uses `cfg_sel` 0 for start, 1 for length and 2 for pointer. A start write sets the pointer to the new start. A length write sets the pointer to the current start. A pointer write sets the pointer directly. A write in cycle N is visible to requests from cycle N+1 on, once any stall has ended.
- R9: `stall` is high in the same cycle whenever `req_valid` is high and the ring named by the request was written in the previous cycle. A request to any other ring is not stalled.
- R10: While `stall` is high the request is not accepted. `addr_valid` is 0 and `addr_out` is unchanged in the following cycle. A request held until `stall` falls is then accepted.
- R11: A step whose magnitude equals the ring's length leaves the pointer where it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Address request present |
| req_idx | input | $clog2(NUM_BUF) | Ring selected by the request |
| req_step | input | AW | Signed post-modify step |
| cfg_we | input | 1 | Context write strobe |
| cfg_idx | input | $clog2(NUM_BUF) | Ring selected by the write |
| cfg_sel | input | 2 | Field written: 0 start, 1 length, 2 pointer, 3 no effect |
| cfg_data | input | AW | Value written |
| stall | output | 1 | Request held back this cycle |
| addr_valid | output | 1 | `addr_out` carries a new address |
| addr_out | output | AW | Address returned for the last accepted request |

## Verification
Each result has its own due cycle. The returned address and `addr_valid` belong to the edge that accepts the request, so they are due one cycle after it. A context write becomes usable in the cycle after it is issued. `stall` is combinational in the cycle the request is presented. The bench drives every input on a falling edge and reads outputs on the next falling edge. It reads `stall` a moment after driving the request within that same low phase. Held-request cases are read on two successive falling edges, so both the blocked cycle and the accepting cycle are observed.

// File: rtl/cag_pkg.sv
package cag_pkg;

    // Field selected by a context write
    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_LEN  = 2'd1,
        SEL_PTR  = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

endpackage

// File: rtl/cag_wrap.sv
// Post-modify with wrap: base + ((ptr - base + step) mod len), linear when len is 0
module cag_wrap #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] len,
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] step,
    output logic [AW-1:0] next_ptr
);
    localparam int SW = AW + 2;

    logic [AW-1:0]        off;
    logic signed [SW-1:0] off_s;
    logic signed [SW-1:0] len_s;
    logic signed [SW-1:0] step_s;
    logic signed [SW-1:0] sum_s;
    logic signed [SW-1:0] fold_s;

    always_comb begin
        off    = ptr - base;
        off_s  = signed'({2'b00, off});
        len_s  = signed'({2'b00, len});
        step_s = signed'({{2{step[AW-1]}}, step});
        sum_s  = off_s + step_s;
        if (sum_s < 0) begin
            fold_s = sum_s + len_s;
        end else if (sum_s >= len_s) begin
            fold_s = sum_s - len_s;
        end else begin
            fold_s = sum_s;
        end
        if (len == '0) begin
            next_ptr = ptr + step;
        end else begin
            next_ptr = base + fold_s[AW-1:0];
        end
    end

endmodule

// File: rtl/cag_hazard.sv
// Dependency interlock: a request to a ring whose write has not yet retired is held
module cag_hazard #(
    parameter int IW = 3
) (
    input  logic          req_valid,
    input  logic [IW-1:0] req_idx,
    input  logic          pend_v,
    input  logic [IW-1:0] pend_idx,
    output logic          stall
);
    assign stall = req_valid & pend_v & (pend_idx == req_idx);
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen #(
    parameter int NUM_BUF = 8,
    parameter int AW      = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [$clog2(NUM_BUF)-1:0] req_idx,
    input  logic [AW-1:0]              req_step,
    input  logic                       cfg_we,
    input  logic [$clog2(NUM_BUF)-1:0] cfg_idx,
    input  logic [1:0]                 cfg_sel,
    input  logic [AW-1:0]              cfg_data,
    output logic                       stall,
    output logic                       addr_valid,
    output logic [AW-1:0]              addr_out
);
    import cag_pkg::*;

    localparam int IW = $clog2(NUM_BUF);

    typedef struct packed {
        logic [NUM_BUF-1:0][AW-1:0] base;
        logic [NUM_BUF-1:0][AW-1:0] len;
        logic [NUM_BUF-1:0][AW-1:0] ptr;
        logic                       pend_v;
        logic [IW-1:0]              pend_idx;
        cfg_sel_e                   pend_sel;
        logic [AW-1:0]              pend_data;
        logic                       out_v;
        logic [AW-1:0]              out_addr;
    } state_t;

    state_t        st_d, st_q;
    logic [AW-1:0] wrap_next;
    logic          hold;
    logic          accept;

    cag_hazard #(.IW(IW)) i_hazard (
        .req_valid (req_valid),
        .req_idx   (req_idx),
        .pend_v    (st_q.pend_v),
        .pend_idx  (st_q.pend_idx),
        .stall     (hold)
    );

    cag_wrap #(.AW(AW)) i_wrap (
        .base     (st_q.base[req_idx]),
        .len      (st_q.len[req_idx]),
        .ptr      (st_q.ptr[req_idx]),
        .step     (req_step),
        .next_ptr (wrap_next)
    );

    assign accept = req_valid & ~hold;

    always_comb begin
        st_d       = st_q;
        st_d.out_v = 1'b0;

        // Accepted request: return the current pointer, store the post-modified one
        if (accept) begin
            st_d.out_v          = 1'b1;
            st_d.out_addr       = st_q.ptr[req_idx];
            st_d.ptr[req_idx]   = wrap_next;
        end

        // Retire the write captured in the previous cycle
        if (st_q.pend_v) begin
            case (st_q.pend_sel)
                SEL_BASE: begin
                    st_d.base[st_q.pend_idx] = st_q.pend_data;
                    st_d.ptr[st_q.pend_idx]  = st_q.pend_data;
                end
                SEL_LEN: begin
                    st_d.len[st_q.pend_idx]  = st_q.pend_data;
                    st_d.ptr[st_q.pend_idx]  = st_q.base[st_q.pend_idx];
                end
                SEL_PTR: begin
                    st_d.ptr[st_q.pend_idx]  = st_q.pend_data;
                end
                default: begin
                end
            endcase
        end

        // Capture a new write
        st_d.pend_v = cfg_we;
        if (cfg_we) begin
            st_d.pend_idx  = cfg_idx;
            st_d.pend_sel  = cfg_sel_e'(cfg_sel);
            st_d.pend_data = cfg_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stall      = hold;
    assign addr_valid = st_q.out_v;
    assign addr_out   = st_q.out_addr;

endmodule

// File: rtl/circ_addr_gen_chk.sv
module circ_addr_gen_chk #(
    parameter int NUM_BUF = 8,
    parameter int AW      = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic [$clog2(NUM_BUF)-1:0] req_idx,
    input logic [AW-1:0]              req_step,
    input logic                       cfg_we,
    input logic [$clog2(NUM_BUF)-1:0] cfg_idx,
    input logic [1:0]                 cfg_sel,
    input logic [AW-1:0]              cfg_data,
    input logic                       stall,
    input logic                       addr_valid,
    input logic [AW-1:0]              addr_out
);

    // R2: an accepted request yields an address in the next cycle
    a_r2_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !stall) |=> addr_valid);

    // R2: no address without an accepted request one cycle earlier
    a_r2_valid_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> ($past(req_valid) && !$past(stall)));

    // R9: a stall only follows a write to the requested ring
    a_r9_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> ($past(cfg_we) && ($past(cfg_idx) == req_idx)));

    // R9: no stall without a request
    a_r9_stall_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> req_valid);

    // R10: a stalled cycle produces no address and keeps the output
    a_r10_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (!addr_valid && $stable(addr_out)));

endmodule

bind circ_addr_gen circ_addr_gen_chk #(.NUM_BUF(NUM_BUF), .AW(AW)) i_chk (.*);

// File: tb/test_circ_addr_gen.sv
module test_circ_addr_gen;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 8;
    localparam int AW         = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_idx = '0;
    logic [AW-1:0] req_step = '0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_idx = '0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_data = '0;
    logic          stall;
    logic          addr_valid;
    logic [AW-1:0] addr_out;

    int n_total = 0;
    int n_fail  = 0;

    circ_addr_gen #(.NUM_BUF(NB), .AW(AW)) i_circ_addr_gen (
        .clk, .rst_n, .req_valid, .req_idx, .req_step,
        .cfg_we, .cfg_idx, .cfg_sel, .cfg_data,
        .stall, .addr_valid, .addr_out
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [2:0]  idx;
        logic [31:0] step;
        logic [31:0] addr;
    } vec_t;

    // Rings: 0 start 0x100 len 10, 1 start 0x1003 len 7, 2 linear ptr 0x500, 3 start 0x2000 len 1
    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 32'(3),      32'h0000_0100},  // R2
        '{3'd0, 32'(4),      32'h0000_0103},  // R2
        '{3'd0, 32'(4),      32'h0000_0107},  // R3 next 0x101
        '{3'd1, 32'(-2),     32'h0000_1003},  // R4 R5 next 0x1008
        '{3'd0, 32'(-1),     32'h0000_0101},
        '{3'd1, 32'(3),      32'h0000_1008},  // R3 R5 next 0x1004
        '{3'd0, 32'(-10),    32'h0000_0100},  // R11
        '{3'd0, 32'(10),     32'h0000_0100},  // R11
        '{3'd0, 32'(9),      32'h0000_0100},
        '{3'd0, 32'(1),      32'h0000_0109},  // R3 next 0x100
        '{3'd2, 32'h40,      32'h0000_0500},  // R6
        '{3'd2, 32'(-32'sh600), 32'h0000_0540},  // R6
        '{3'd2, 32'hC0,      32'hFFFF_FF40},  // R6 modulo 2^AW
        '{3'd2, 32'(0),      32'h0000_0000},
        '{3'd1, 32'(-7),     32'h0000_1004},  // R11
        '{3'd3, 32'(1),      32'h0000_2000},
        '{3'd3, 32'(-1),     32'h0000_2000},
        '{3'd1, 32'(6),      32'h0000_1004},  // R3 next 0x1003
        '{3'd1, 32'(0),      32'h0000_1003}
    };

    task automatic check(input bit ok, input string tag,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [2:0] idx, input logic [1:0] sel, input logic [AW-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_sel = sel; cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_req(input logic [2:0] idx, input logic [AW-1:0] step,
                          input logic [AW-1:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_idx = idx; req_step = step;
        #1;
        check(stall === 1'b0, {tag, " no stall"}, {31'b0, stall}, '0);
        @(negedge clk);
        req_valid = 1'b0;
        check(addr_valid === 1'b1 && addr_out === exp, tag, addr_out, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        logic [AW-1:0] held;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(addr_valid === 1'b0, "R1 addr_valid in reset", {31'b0, addr_valid}, '0);
        check(addr_out === '0, "R1 addr_out in reset", addr_out, '0);
        check(stall === 1'b0, "R1 stall in reset", {31'b0, stall}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(addr_valid === 1'b0 && addr_out === '0, "R1 after reset", addr_out, '0);
        // R1: untouched ring has start 0 length 0 pointer 0, so it steps linearly
        do_req(3'd5, 32'(5), 32'h0, "R1 ring5 first");
        do_req(3'd5, 32'(0), 32'h5, "R1 ring5 linear");

        // Setup
        cfg(3'd0, 2'd0, 32'h100);
        cfg(3'd0, 2'd1, 32'd10);
        cfg(3'd1, 2'd0, 32'h1003);
        cfg(3'd1, 2'd1, 32'd7);
        cfg(3'd2, 2'd2, 32'h500);   // R8 pointer write
        cfg(3'd3, 2'd0, 32'h2000);
        cfg(3'd3, 2'd1, 32'd1);

        for (int i = 0; i < NV; i++) begin
            do_req(VECS[i].idx, VECS[i].step, VECS[i].addr, $sformatf("R2 table row %0d", i));
        end

        // R9 R10: request on the cycle after a write to the same ring
        held = addr_out;
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'd0; cfg_sel = 2'd0; cfg_data = 32'h300;
        @(negedge clk);
        cfg_we = 1'b0;
        req_valid = 1'b1; req_idx = 3'd0; req_step = 32'(1);
        #1;
        check(stall === 1'b1, "R9 stall on dependent request", {31'b0, stall}, 32'h1);
        @(negedge clk);
        check(stall === 1'b0, "R9 stall clears after retire", {31'b0, stall}, '0);
        check(addr_valid === 1'b0, "R10 no address while stalled", {31'b0, addr_valid}, '0);
        check(addr_out === held, "R10 addr_out held", addr_out, held);
        @(negedge clk);
        req_valid = 1'b0;
        check(addr_valid === 1'b1 && addr_out === 32'h300, "R10 R8 held request sees new start",
              addr_out, 32'h300);
        do_req(3'd0, 32'(0), 32'h301, "R8 post-modify after start write");

        // R8: length write resets pointer to start
        cfg(3'd0, 2'd1, 32'd4);
        do_req(3'd0, 32'(3), 32'h300, "R8 length write resets pointer");
        do_req(3'd0, 32'(3), 32'h303, "R3 new length");
        do_req(3'd0, 32'(0), 32'h302, "R3 wrap with length 4");

        // R9: write to another ring does not stall
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'd4; cfg_sel = 2'd1; cfg_data = 32'd5;
        @(negedge clk);
        cfg_we = 1'b0;
        req_valid = 1'b1; req_idx = 3'd1; req_step = 32'(0);
        #1;
        check(stall === 1'b0, "R9 other ring not stalled", {31'b0, stall}, '0);
        @(negedge clk);
        req_valid = 1'b0;
        check(addr_valid === 1'b1 && addr_out === 32'h1003, "R9 other ring accepted",
              addr_out, 32'h1003);

        // R2: back-to-back requests on ring 4 (start 0, length 5)
        @(negedge clk);
        req_valid = 1'b1; req_idx = 3'd4; req_step = 32'(2);
        @(negedge clk);
        check(stall === 1'b0 && addr_valid === 1'b1 && addr_out === 32'h0,
              "R2 back-to-back first", addr_out, 32'h0);
        @(negedge clk);
        req_valid = 1'b0;
        check(addr_valid === 1'b1 && addr_out === 32'h2, "R2 back-to-back second", addr_out, 32'h2);
        do_req(3'd4, 32'(2), 32'h4, "R2 third");
        do_req(3'd4, 32'(0), 32'h1, "R3 ring4 wrap");

        // R7: independent rings
        cfg(3'd6, 2'd0, 32'h7000);
        cfg(3'd6, 2'd1, 32'd3);
        cfg(3'd7, 2'd0, 32'h8000);
        cfg(3'd7, 2'd1, 32'd5);
        do_req(3'd7, 32'(-1), 32'h8000, "R7 ring7");
        do_req(3'd6, 32'(2),  32'h7000, "R7 ring6");
        do_req(3'd7, 32'(0),  32'h8004, "R7 R4 ring7 wrap");
        do_req(3'd6, 32'(2),  32'h7002, "R7 ring6 second");
        do_req(3'd6, 32'(0),  32'h7001, "R7 R3 ring6 wrap");
        do_req(3'd0, 32'(0),  32'h302,  "R7 ring0 untouched");
        do_req(3'd1, 32'(0),  32'h1003, "R7 ring1 untouched");
        do_req(3'd3, 32'(0),  32'h2000, "R7 ring3 untouched");
        do_req(3'd2, 32'(0),  32'h0,    "R7 R6 ring2 untouched");

        @(negedge clk);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule